// File: doc/BRIEF.md
# Read Strobe Enable Calibration Sequencer

This block searches, one byte group at a time, for the read strobe preamble so that the strobe-enable gate of each group opens at the right moment. For every trial setting it sends a short burst of read commands with one idle cycle between each pair. The read path then reports, once per inter-read gap, which data bits saw the strobe gap that this spacing produces. A trial setting passes when enough gaps are seen.

The search is two loops, one inside the other. An outer coarse FIFO latency step starts at zero. At each coarse step an inner fine enable delay sweeps upward from zero. The fine delay advances after every failed burst. When the fine delay is exhausted, the coarse step advances and the fine delay restarts. The first passing setting ends the search for that group. Its coarse value is stored, and so is its fine value plus a margin. If the top coarse step also fails, the group is marked failed and the sequencer moves on. Per-bit deskew has not yet been done at this stage, so one good bit is enough for a gap to count.

Top module: `rdgate_cal`

## Requirements
- R1: While a burst is issued, `rd_cmd` pulses exactly 8 times in a row of high, low, high, ..., high (one idle cycle between reads). `rd_cmd` is never high in two consecutive cycles and never high while `cal_busy` is low.
- R2: Each `obs_valid` cycle reports one inter-read gap. The gap counts as seen when any bit of `obs_bits` is 1, so a single set bit is enough.
- R3: A setting passes when at least 6 of the 7 gap reports in its burst are seen. With 5 or fewer seen it fails.
- R4: After a failed setting whose fine value is below 31, the next burst uses the same group and coarse value with the fine value plus one.
- R5: After a failed setting at fine 31 with coarse below 15, the next burst uses coarse plus one and fine 0.
- R6: Groups are calibrated in order 0 to NUM_GRP-1, and each starts at coarse 0, fine 0. `set_grp`, `set_coarse` and `set_fine` stay stable for the whole burst.
- R7: When a group passes, its result holds the passing coarse value, fail flag 0, and fine = first passing fine + FINE_MARGIN (default 2), saturated at 31.
- R8: When coarse 15, fine 31 fails, the group's result holds fail flag 1, coarse 15 and fine 0, and calibration goes on with the next group.
- R9: Reset gives `cal_busy`=0, `cal_done`=0, `rd_cmd`=0 and all results zero. After the last group, `cal_busy` falls and `cal_done` stays high until the next start. `res_sel` selects the result shown on `res_fine`, `res_coarse` and `res_fail` in the same cycle.
- R10: `cal_start` has no effect while `cal_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Start a full calibration pass |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration finished, held until next start |
| rd_cmd | output | 1 | Read command pulse |
| set_grp | output | GRP_W (2) | Group under calibration |
| set_coarse | output | CRS_W (4) | Coarse latency step applied |
| set_fine | output | FINE_W (5) | Fine enable delay applied |
| obs_valid | input | 1 | One inter-read gap report is present |
| obs_bits | input | DQ_W (8) | Per-bit gap seen flags for that report |
| res_sel | input | GRP_W (2) | Group whose result is shown |
| res_fine | output | FINE_W (5) | Stored fine result |
| res_coarse | output | CRS_W (4) | Stored coarse result |
| res_fail | output | 1 | Stored fail flag |

## Verification
The bench sets a hidden pass region for each group, given by a coarse and fine threshold or by no pass region at all. It answers every burst with gap reports, and it often sits exactly at 5 or 6 seen gaps with only one bit set. A design that counts to the wrong threshold, or that needs all bits, would settle on a different setting or sweep on. A fine target near the top catches a margin that wraps instead of saturating. A group with no pass region catches a coarse counter that wraps or stalls, and a missing fail flag. A start pulse sent mid-run catches a sequencer that restarts, because the sweep order it checks burst by burst would break.

// File: rtl/rdgate_pkg.sv
package rdgate_pkg;
   typedef enum logic [1:0] {
      BU_IDLE,
      BU_ISSUE,
      BU_COLLECT
   } burst_st_t;

   typedef enum logic [1:0] {
      SW_IDLE,
      SW_LAUNCH,
      SW_WAIT,
      SW_DONE
   } sweep_st_t;
endpackage

// File: rtl/rdgate_burst.sv
module rdgate_burst
   import rdgate_pkg::*;
#(
   parameter int BURST_LEN = 8,
   parameter int MIN_HITS  = 6,
   parameter int DQ_W      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            obs_valid,
   input  logic [DQ_W-1:0] obs_bits,
   output logic            rd_cmd,
   output logic            bdone,
   output logic            found
);
   localparam int GAPS      = BURST_LEN - 1;
   localparam int ISSUE_CYC = 2 * BURST_LEN - 1;
   localparam int IW        = $clog2(ISSUE_CYC + 1);
   localparam int GW        = $clog2(GAPS + 1);

   generate
      if (BURST_LEN < 2) begin : g_bad_len
         $error("burst needs at least two reads");
      end
      if (MIN_HITS < 1 || MIN_HITS > GAPS) begin : g_bad_hits
         $error("pass threshold out of range");
      end
   endgenerate

   burst_st_t      st;
   logic [IW-1:0]  icnt;
   logic [GW-1:0]  gcnt;
   logic [GW-1:0]  hcnt;
   logic           rd_q, done_q, found_q;
   logic           gap_seen;

   // any single bit is enough: deskew has not happened yet
   assign gap_seen = |obs_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= BU_IDLE;
         icnt    <= '0;
         gcnt    <= '0;
         hcnt    <= '0;
         rd_q    <= 1'b0;
         done_q  <= 1'b0;
         found_q <= 1'b0;
      end else begin
         rd_q   <= 1'b0;
         done_q <= 1'b0;
         if (st != BU_IDLE && obs_valid && gcnt != GW'(GAPS)) begin
            gcnt <= gcnt + 1'b1;
            if (gap_seen) hcnt <= hcnt + 1'b1;
         end
         case (st)
            BU_IDLE: begin
               if (go) begin
                  st   <= BU_ISSUE;
                  icnt <= IW'(1);
                  gcnt <= '0;
                  hcnt <= '0;
                  rd_q <= 1'b1;
               end
            end
            BU_ISSUE: begin
               if (icnt == IW'(ISSUE_CYC)) begin
                  st <= BU_COLLECT;
               end else begin
                  rd_q <= ~icnt[0];
                  icnt <= icnt + 1'b1;
               end
            end
            BU_COLLECT: begin
               if (gcnt == GW'(GAPS)) begin
                  done_q  <= 1'b1;
                  found_q <= (hcnt >= GW'(MIN_HITS));
                  st      <= BU_IDLE;
               end
            end
            default: st <= BU_IDLE;
         endcase
      end
   end

   assign rd_cmd = rd_q;
   assign bdone  = done_q;
   assign found  = found_q;

   AST_RD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> !rd_cmd); // R1
   AST_RD_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BU_ISSUE && !rd_cmd && icnt != IW'(ISSUE_CYC)) |=> rd_cmd); // R1
endmodule

// File: rtl/rdgate_sweep.sv
module rdgate_sweep
   import rdgate_pkg::*;
#(
   parameter int NUM_GRP     = 4,
   parameter int FINE_W      = 5,
   parameter int CRS_W       = 4,
   parameter int FINE_MARGIN = 2,
   localparam int GRP_W      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bdone,
   input  logic              found,
   output logic              go,
   output logic              busy,
   output logic              done,
   output logic [GRP_W-1:0]  grp,
   output logic [CRS_W-1:0]  crs,
   output logic [FINE_W-1:0] fine,
   output logic              wr_en,
   output logic [FINE_W-1:0] wr_fine,
   output logic [CRS_W-1:0]  wr_crs,
   output logic              wr_fail
);
   localparam logic [FINE_W-1:0] FMAX = '1;
   localparam logic [CRS_W-1:0]  CMAX = '1;
   localparam logic [GRP_W-1:0]  GLAST = GRP_W'(NUM_GRP - 1);

   generate
      if (FINE_MARGIN < 0 || FINE_MARGIN >= (1 << FINE_W)) begin : g_bad_margin
         $error("fine margin out of range");
      end
      if (NUM_GRP < 1) begin : g_bad_grp
         $error("need at least one group");
      end
   endgenerate

   sweep_st_t       st;
   logic            exhausted;
   logic [FINE_W:0] fine_sum;

   assign exhausted = !found && fine == FMAX && crs == CMAX;
   assign fine_sum  = {1'b0, fine} + (FINE_W + 1)'(FINE_MARGIN);

   assign go    = (st == SW_LAUNCH);
   assign busy  = (st == SW_LAUNCH) || (st == SW_WAIT);
   assign done  = (st == SW_DONE);
   assign wr_en = (st == SW_WAIT) && bdone && (found || exhausted);
   assign wr_fail = !found;
   assign wr_crs  = crs;
   assign wr_fine = !found ? '0 : (fine_sum[FINE_W] ? FMAX : fine_sum[FINE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SW_IDLE;
         grp  <= '0;
         crs  <= '0;
         fine <= '0;
      end else begin
         case (st)
            SW_IDLE, SW_DONE: begin
               if (start) begin
                  st   <= SW_LAUNCH;
                  grp  <= '0;
                  crs  <= '0;
                  fine <= '0;
               end
            end
            SW_LAUNCH: st <= SW_WAIT;
            SW_WAIT: begin
               if (bdone) begin
                  if (found || exhausted) begin
                     crs  <= '0;
                     fine <= '0;
                     if (grp == GLAST) begin
                        st <= SW_DONE;
                     end else begin
                        grp <= grp + 1'b1;
                        st  <= SW_LAUNCH;
                     end
                  end else if (fine == FMAX) begin
                     crs  <= crs + 1'b1;
                     fine <= '0;
                     st   <= SW_LAUNCH;
                  end else begin
                     fine <= fine + 1'b1;
                     st   <= SW_LAUNCH;
                  end
               end
            end
            default: st <= SW_IDLE;
         endcase
      end
   end

   AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SW_WAIT && bdone && !found && fine != FMAX)
      |=> (fine == FINE_W'($past(fine) + 1'b1) && crs == $past(crs) && grp == $past(grp))); // R4
   AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SW_WAIT && bdone && !found && fine == FMAX && crs != CMAX)
      |=> (fine == '0 && crs == CRS_W'($past(crs) + 1'b1))); // R5
   AST_HOLD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SW_WAIT && !bdone) |=> ($stable(grp) && $stable(crs) && $stable(fine))); // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SW_WAIT && start && !bdone) |=> st == SW_WAIT); // R10
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R9
endmodule

// File: rtl/rdgate_results.sv
module rdgate_results #(
   parameter int NUM_GRP = 4,
   parameter int FINE_W  = 5,
   parameter int CRS_W   = 4,
   localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GRP_W-1:0]  wr_grp,
   input  logic [FINE_W-1:0] wr_fine,
   input  logic [CRS_W-1:0]  wr_crs,
   input  logic              wr_fail,
   input  logic [GRP_W-1:0]  rd_sel,
   output logic [FINE_W-1:0] rd_fine,
   output logic [CRS_W-1:0]  rd_crs,
   output logic              rd_fail
);
   logic [FINE_W-1:0] fine_r [NUM_GRP];
   logic [CRS_W-1:0]  crs_r  [NUM_GRP];
   logic              fail_r [NUM_GRP];

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fine_r[g] <= '0;
               crs_r[g]  <= '0;
               fail_r[g] <= 1'b0;
            end else if (wr_en && wr_grp == GRP_W'(g)) begin
               fine_r[g] <= wr_fine;
               crs_r[g]  <= wr_crs;
               fail_r[g] <= wr_fail;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_fine = '0;
      rd_crs  = '0;
      rd_fail = 1'b0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (rd_sel == GRP_W'(g)) begin
            rd_fine = fine_r[g];
            rd_crs  = crs_r[g];
            rd_fail = fail_r[g];
         end
      end
   end

   AST_FAIL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_fail) |-> wr_crs == '1); // R8
endmodule

// File: rtl/rdgate_cal.sv
module rdgate_cal #(
   parameter int NUM_GRP     = 4,
   parameter int DQ_W        = 8,
   parameter int FINE_W      = 5,
   parameter int CRS_W       = 4,
   parameter int BURST_LEN   = 8,
   parameter int MIN_HITS    = 6,
   parameter int FINE_MARGIN = 2,
   localparam int GRP_W      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cal_start,
   output logic              cal_busy,
   output logic              cal_done,
   output logic              rd_cmd,
   output logic [GRP_W-1:0]  set_grp,
   output logic [CRS_W-1:0]  set_coarse,
   output logic [FINE_W-1:0] set_fine,
   input  logic              obs_valid,
   input  logic [DQ_W-1:0]   obs_bits,
   input  logic [GRP_W-1:0]  res_sel,
   output logic [FINE_W-1:0] res_fine,
   output logic [CRS_W-1:0]  res_coarse,
   output logic              res_fail
);
   logic              go, bdone, found, wr_en, wr_fail;
   logic [FINE_W-1:0] wr_fine;
   logic [CRS_W-1:0]  wr_crs;

   rdgate_burst #(
      .BURST_LEN (BURST_LEN),
      .MIN_HITS  (MIN_HITS),
      .DQ_W      (DQ_W)
   ) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .obs_valid (obs_valid),
      .obs_bits  (obs_bits),
      .rd_cmd    (rd_cmd),
      .bdone     (bdone),
      .found     (found)
   );

   rdgate_sweep #(
      .NUM_GRP     (NUM_GRP),
      .FINE_W      (FINE_W),
      .CRS_W       (CRS_W),
      .FINE_MARGIN (FINE_MARGIN)
   ) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cal_start),
      .bdone   (bdone),
      .found   (found),
      .go      (go),
      .busy    (cal_busy),
      .done    (cal_done),
      .grp     (set_grp),
      .crs     (set_coarse),
      .fine    (set_fine),
      .wr_en   (wr_en),
      .wr_fine (wr_fine),
      .wr_crs  (wr_crs),
      .wr_fail (wr_fail)
   );

   rdgate_results #(
      .NUM_GRP (NUM_GRP),
      .FINE_W  (FINE_W),
      .CRS_W   (CRS_W)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_grp  (set_grp),
      .wr_fine (wr_fine),
      .wr_crs  (wr_crs),
      .wr_fail (wr_fail),
      .rd_sel  (res_sel),
      .rd_fine (res_fine),
      .rd_crs  (res_coarse),
      .rd_fail (res_fail)
   );

   AST_RD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |-> cal_busy); // R1
endmodule

// File: tb/rdgate_cal_tb.sv
`timescale 1ns/1ps
module rdgate_cal_tb;
   localparam int NG = 4;
   localparam int DQ = 8;
   localparam int BL = 8;
   localparam int FM = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cal_start;
   logic       cal_busy, cal_done, rd_cmd;
   logic [1:0] set_grp;
   logic [3:0] set_coarse;
   logic [4:0] set_fine;
   logic       obs_valid;
   logic [7:0] obs_bits;
   logic [1:0] res_sel;
   logic [4:0] res_fine;
   logic [3:0] res_coarse;
   logic       res_fail;

   always #2 clk = ~clk;

   rdgate_cal u_dut (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_busy(cal_busy),
      .cal_done(cal_done), .rd_cmd(rd_cmd), .set_grp(set_grp),
      .set_coarse(set_coarse), .set_fine(set_fine), .obs_valid(obs_valid),
      .obs_bits(obs_bits), .res_sel(res_sel), .res_fine(res_fine),
      .res_coarse(res_coarse), .res_fail(res_fail)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int tc [NG];
   int tf [NG];
   bit nev [NG];
   int eg, ec, ef;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit truth_pass(input int g, input int c, input int f);
      if (nev[g]) return 1'b0;
      return (c > tc[g]) || (c == tc[g] && f >= tf[g]);
   endfunction

   function automatic int exp_fine(input int f);
      return (f + FM > 31) ? 31 : f + FM;
   endfunction

   // read path model: watches the read bursts and answers with gap reports
   initial begin
      int nread = 0;
      int last  = 0;
      obs_valid = 1'b0;
      obs_bits  = '0;
      forever begin
         @(negedge clk);
         if (rd_cmd) begin
            if (!cal_busy) chk(1'b0, "R1", "read while idle", 1, 0);
            if (nread > 0) chk(cyc - last == 2, "R1", "read spacing", cyc - last, 2);
            last = cyc;
            nread++;
            if (nread == BL) begin
               int hits, need, left;
               bit pass;
               nread = 0;
               chk(set_grp == eg, "R6", "burst group", set_grp, eg);
               chk(set_coarse == ec, "R5", "burst coarse", set_coarse, ec);
               chk(set_fine == ef, "R4", "burst fine", set_fine, ef);
               if (truth_pass(eg, ec, ef)) hits = 6 + int'($urandom % 2);
               else if ($urandom % 3 == 0) hits = 5;
               else hits = int'($urandom % 6);
               need = hits;
               for (int i = 0; i < BL - 1; i++) begin
                  bit seen;
                  left = BL - 1 - i;
                  seen = (need == left) || (need > 0 && ($urandom % 2 == 1));
                  if (seen) need--;
                  @(negedge clk);
                  obs_valid = 1'b1;
                  // R2: a seen gap carries only one good data bit
                  obs_bits  = seen ? (8'd1 << ($urandom % DQ)) : 8'd0;
               end
               @(negedge clk);
               obs_valid = 1'b0;
               obs_bits  = '0;
               // R3: pass needs at least 6 of 7 seen gaps
               pass = (hits >= 6);
               if (pass || (ef == 31 && ec == 15)) begin
                  eg++; ec = 0; ef = 0;
               end else if (ef == 31) begin
                  ec++; ef = 0;
               end else begin
                  ef++;
               end
            end
         end
      end
   end

   task automatic run_cal(input bit poke_start);
      eg = 0; ec = 0; ef = 0;
      @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      chk(cal_busy == 1'b1, "R9", "busy after start", cal_busy, 1);
      if (poke_start) begin
         repeat (120) @(negedge clk);
         // R10: a start pulse mid-run must not restart the sweep
         cal_start = 1'b1;
         @(negedge clk);
         cal_start = 1'b0;
      end
      while (!cal_done) @(negedge clk);
      chk(cal_busy == 1'b0, "R9", "busy at end", cal_busy, 0);
      chk(eg == NG, "R6", "groups visited", eg, NG);
      for (int g = 0; g < NG; g++) begin
         res_sel = 2'(g);
         #1;
         if (nev[g]) begin
            chk(res_fail == 1'b1, "R8", "fail flag", res_fail, 1);
            chk(res_coarse == 4'd15, "R8", "fail coarse", res_coarse, 15);
            chk(res_fine == 5'd0, "R8", "fail fine", res_fine, 0);
         end else begin
            chk(res_fail == 1'b0, "R7", "pass flag", res_fail, 0);
            chk(res_coarse == tc[g], "R7", "pass coarse", res_coarse, tc[g]);
            chk(res_fine == exp_fine(tf[g]), "R7", "pass fine", res_fine, exp_fine(tf[g]));
         end
      end
      repeat (10) @(negedge clk);
      chk(cal_done == 1'b1, "R9", "done held", cal_done, 1);
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n     = 1'b0;
      cal_start = 1'b0;
      res_sel   = '0;
      repeat (4) @(negedge clk);
      chk(cal_busy == 1'b0, "R9", "reset busy", cal_busy, 0);
      chk(cal_done == 1'b0, "R9", "reset done", cal_done, 0);
      chk(rd_cmd == 1'b0, "R9", "reset rd_cmd", rd_cmd, 0);
      for (int g = 0; g < NG; g++) begin
         res_sel = 2'(g);
         #1;
         chk({res_fail, res_coarse, res_fine} == 10'd0, "R9", "reset result",
             {res_fail, res_coarse, res_fine}, 0);
      end
      rst_n = 1'b1;

      // directed: immediate pass, saturating margin, never passes, mid value
      tc[0] = 0; tf[0] = 0;  nev[0] = 0;
      tc[1] = 1; tf[1] = 30; nev[1] = 0;
      tc[2] = 0; tf[2] = 0;  nev[2] = 1;
      tc[3] = 2; tf[3] = 5;  nev[3] = 0;
      run_cal(1'b1);

      // random targets
      for (int g = 0; g < NG; g++) begin
         tc[g]  = int'($urandom % 3);
         tf[g]  = int'($urandom % 32);
         nev[g] = 1'b0;
      end
      run_cal(1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule